// File: doc/BRIEF.md
# Output Compare Unit with Master Override

This block runs a 16-bit counter that counts up on every clock and compares it against one register per channel across eight channels. When the counter equals a channel's compare value, and that channel is in compare mode, the channel raises its flag. It also applies its 2-bit action code to its pin. The code can toggle the pin, drive it low, drive it high, or leave it alone.

The highest channel (channel 7) is the master. When the master matches, every channel whose bit is set in the override mask, and which is in compare mode, loads its pin from the matching bit of the override data register. If the master and a masked channel match on the same count, the override data wins. If they match on different counts, the pin follows both events in the order they occur. Software configures the block through a single-cycle register write port.

Top module: `oc_master_unit`

## Requirements
- R1: The counter output is 0 during reset. It increases by 1 on every clock after reset and wraps from 0xFFFF to 0.
- R2: A channel matches when its mode bit is 1 and the counter equals its compare register. A match sets that channel's flag bit on the same clock edge.
  - Writing a word to the flag-clear address clears each flag whose bit in the word is 1.
  - Bits written as 0 leave their flags unchanged.
  - A match on the same edge as a clear leaves the flag set.
- R3: The action code of channel x sits in bits [2x+1:2x] of the action register, as {high bit, low bit}. On a match of that channel, the pin changes at the match edge as follows:
  - 01 toggles the pin.
  - 10 drives the pin to 0.
  - 11 drives the pin to 1.
  - 00 leaves the pin unchanged.
- R4: A channel's pin enable is 1 exactly when its mode bit is 1 and either its action code is not 00 or its override mask bit is 1.
- R5: When channel 7 matches, every channel with mode bit 1 and mask bit 1 loads its override data bit into its pin. Channels with mask bit 0 are not affected by channel 7's match.
- R6: If channel 7 and a masked channel x match on the same edge, pin x takes the override data bit and channel x's own action is not applied.
- R7: If channel 7 and a masked channel x match on different edges, pin x takes the override data bit at channel 7's match and applies its own action at its own match, in that order.
- R8: Channel 7's own pin follows its action code when its mask bit is 0. It takes override data bit 7 on its match when its mask bit is 1.
- R9: A channel with mode bit 0 never matches. Its flag is not set and its pin does not change.
- R10: After reset all pins, pin enables and flags are 0, and the mode, action, mask and data registers are 0.
- R11: The write addresses are as follows. A write takes effect on the following cycle.

| Address | Register |
|---|---|
| 0 to 7 | Compare registers of channels 0 to 7 |
| 8 | Mode bits |
| 9 | Action codes |
| 10 | Override mask |
| 11 | Override data |
| 12 | Flag clear |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| cnt_o | output | 16 | Current counter value |
| pin_o | output | 8 | Per-channel pin level |
| pin_oe_o | output | 8 | Per-channel pin drive enable |
| flag_o | output | 8 | Per-channel compare flags |

## Verification
A corrupted pin register shows at `pin_o` on the cycle after the match edge that should have set it, and it stays wrong until the next event for that channel. A wrong override-priority decision shows up only on the edges where channel 7 and a masked channel coincide, so the same-count case and both staggered orders are driven explicitly. A flag stuck high or lost shows at `flag_o` one cycle after a match or a clear write. A counter fault shifts every later match and is visible directly at `cnt_o` within one cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;

   typedef enum logic [1:0] {
      OC_ACT_OFF = 2'b00,
      OC_ACT_TOG = 2'b01,
      OC_ACT_CLR = 2'b10,
      OC_ACT_SET = 2'b11
   } oc_act_e;

   // register bus width: wide enough for a compare word and all action codes
   function automatic int oc_bus_w(input int cw, input int nch);
      return (cw > 2 * nch) ? cw : 2 * nch;
   endfunction

   // compare slots plus mode, action, mask, data and flag-clear
   function automatic int oc_addr_w(input int nch);
      return $clog2(nch + 5);
   endfunction

endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= cnt_o + 1'b1;
   end

endmodule

// File: rtl/oc_regs.sv
module oc_regs #(
   parameter int NCH = 8,
   parameter int CW  = 16,
   parameter int AW  = 4,
   parameter int DW  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic [DW-1:0]           wr_data,
   input  logic [NCH-1:0]          match_i,
   output logic [NCH-1:0][CW-1:0]  cmp_o,
   output logic [NCH-1:0]          mode_o,
   output logic [2*NCH-1:0]        act_o,
   output logic [NCH-1:0]          mask_o,
   output logic [NCH-1:0]          data_o,
   output logic [NCH-1:0]          flag_o
);

   localparam int A_MODE = NCH;
   localparam int A_ACT  = NCH + 1;
   localparam int A_MASK = NCH + 2;
   localparam int A_DATA = NCH + 3;
   localparam int A_FCLR = NCH + 4;

   logic sel_mode, sel_act, sel_mask, sel_data, sel_fclr;

   always_comb begin
      sel_mode = wr_en && (wr_addr == AW'(A_MODE));
      sel_act  = wr_en && (wr_addr == AW'(A_ACT));
      sel_mask = wr_en && (wr_addr == AW'(A_MASK));
      sel_data = wr_en && (wr_addr == AW'(A_DATA));
      sel_fclr = wr_en && (wr_addr == AW'(A_FCLR));
   end

   // one compare register per channel
   for (genvar g = 0; g < NCH; g++) begin : g_cmp
      always_ff @(posedge clk) begin
         if (!rst_n)
            cmp_o[g] <= '0;
         else if (wr_en && (wr_addr == AW'(g)))
            cmp_o[g] <= wr_data[CW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_o <= '0;
         act_o  <= '0;
         mask_o <= '0;
         data_o <= '0;
      end else begin
         if (sel_mode) mode_o <= wr_data[NCH-1:0];
         if (sel_act)  act_o  <= wr_data[2*NCH-1:0];
         if (sel_mask) mask_o <= wr_data[NCH-1:0];
         if (sel_data) data_o <= wr_data[NCH-1:0];
      end
   end

   // flags: a match on the same edge outranks a clear
   for (genvar g = 0; g < NCH; g++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            flag_o[g] <= 1'b0;
         else if (match_i[g])
            flag_o[g] <= 1'b1;
         else if (sel_fclr && wr_data[g])
            flag_o[g] <= 1'b0;
      end
   end

endmodule

// File: rtl/oc_channel.sv
module oc_channel
   import oc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_i,
   input  logic [1:0] act_i,
   input  logic       mask_i,
   input  logic       data_i,
   input  logic       match_i,
   input  logic       mst_i,
   output logic       pin_o,
   output logic       oe_o
);

   logic    override;
   oc_act_e act;

   always_comb begin
      act      = oc_act_e'(act_i);
      override = mode_i && mask_i && mst_i;
      oe_o     = mode_i && ((act != OC_ACT_OFF) || mask_i);
   end

   // the master's data outranks the channel's own action on a shared edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_o <= 1'b0;
      end else if (override) begin
         pin_o <= data_i;
      end else if (match_i) begin
         case (act)
            OC_ACT_TOG: pin_o <= ~pin_o;
            OC_ACT_CLR: pin_o <= 1'b0;
            OC_ACT_SET: pin_o <= 1'b1;
            default:    pin_o <= pin_o;
         endcase
      end
   end

endmodule

// File: rtl/oc_master_unit.sv
module oc_master_unit
   import oc_pkg::*;
#(
   parameter  int NCH = 8,
   parameter  int CW  = 16,
   localparam int AW  = oc_addr_w(NCH),
   localparam int DW  = oc_bus_w(CW, NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [DW-1:0]  wr_data,
   output logic [CW-1:0]  cnt_o,
   output logic [NCH-1:0] pin_o,
   output logic [NCH-1:0] pin_oe_o,
   output logic [NCH-1:0] flag_o
);

   localparam int MST = NCH - 1;

   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("oc_master_unit: NCH must be 2..16");
   end
   if (CW < 4) begin : g_bad_cw
      $error("oc_master_unit: CW must be at least 4");
   end

   logic [NCH-1:0][CW-1:0] cmp;
   logic [NCH-1:0]         mode, mask, data, match;
   logic [2*NCH-1:0]       act;

   oc_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt_o (cnt_o)
   );

   oc_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .match_i (match),
      .cmp_o   (cmp),
      .mode_o  (mode),
      .act_o   (act),
      .mask_o  (mask),
      .data_o  (data),
      .flag_o  (flag_o)
   );

   always_comb begin
      for (int i = 0; i < NCH; i++)
         match[i] = mode[i] && (cnt_o == cmp[i]);
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      oc_channel u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .mode_i  (mode[g]),
         .act_i   (act[2*g +: 2]),
         .mask_i  (mask[g]),
         .data_i  (data[g]),
         .match_i (match[g]),
         .mst_i   (match[MST]),
         .pin_o   (pin_o[g]),
         .oe_o    (pin_oe_o[g])
      );
   end

endmodule

// File: rtl/oc_master_unit_chk.sv
module oc_master_unit_chk #(
   parameter int NCH = 8,
   parameter int CW  = 16,
   parameter int AW  = 4,
   parameter int DW  = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_en,
   input logic [AW-1:0]  wr_addr,
   input logic [DW-1:0]  wr_data,
   input logic [CW-1:0]  cnt,
   input logic [NCH-1:0] match,
   input logic [NCH-1:0] mode,
   input logic [NCH-1:0] mask,
   input logic [NCH-1:0] data,
   input logic [2*NCH-1:0] act,
   input logic [NCH-1:0] pin,
   input logic [NCH-1:0] flag
);

   localparam int MST    = NCH - 1;
   localparam int A_FCLR = NCH + 4;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt == CW'($past(cnt) + 1'b1)); // R1

   for (genvar g = 0; g < NCH; g++) begin : g_chk
      AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
         match[g] |=> flag[g]); // R2
      AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == AW'(A_FCLR) && wr_data[g] && !match[g]) |=> !flag[g]); // R2
      AST_SET_PIN: assert property (@(posedge clk) disable iff (!rst_n)
         (match[g] && !(match[MST] && mask[g]) && act[2*g +: 2] == 2'b11) |=> pin[g]); // R3
      AST_TOG_PIN: assert property (@(posedge clk) disable iff (!rst_n)
         (match[g] && !(match[MST] && mask[g]) && act[2*g +: 2] == 2'b01) |=> pin[g] != $past(pin[g])); // R3
      AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
         (match[MST] && mask[g] && mode[g]) |=> pin[g] == $past(data[g])); // R5
      AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (!match[g] && !(match[MST] && mask[g] && mode[g])) |=> $stable(pin[g])); // R7
      AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         !mode[g] |=> $stable(pin[g])); // R9
   end

endmodule

bind oc_master_unit oc_master_unit_chk #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .cnt     (cnt_o),
   .match   (match),
   .mode    (mode),
   .mask    (mask),
   .data    (data),
   .act     (act),
   .pin     (pin_o),
   .flag    (flag_o)
);

// File: tb/sim_oc_master_unit.sv
module sim_oc_master_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] cnt_o;
   logic [7:0]  pin_o, pin_oe_o, flag_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [7:0]  sh_mode = '0, sh_mask = '0, sh_data = '0;
   logic [15:0] sh_act = '0;

   oc_master_unit u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cnt_o    (cnt_o),
      .pin_o    (pin_o),
      .pin_oe_o (pin_oe_o),
      .flag_o   (flag_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_cnt(input logic [15:0] v);
      do @(negedge clk); while (cnt_o !== v);
   endtask

   task automatic set_ch(input int ch, input bit md, input logic [1:0] ac, input bit mk, input bit dt);
      sh_mode[ch] = md; sh_act[2*ch +: 2] = ac; sh_mask[ch] = mk; sh_data[ch] = dt;
      wr(4'd8, {8'h0, sh_mode});
      wr(4'd9, sh_act);
      wr(4'd10, {8'h0, sh_mask});
      wr(4'd11, {8'h0, sh_data});
   endtask

   task automatic future(output logic [15:0] t);
      @(negedge clk);
      t = cnt_o + 16'd20;
   endtask

   // R10 / R1: reset state and counting
   task automatic t_reset;
      repeat (3) @(negedge clk);
      check("R10 pins", {8'h0, pin_o}, 16'h0);
      check("R10 oe", {8'h0, pin_oe_o}, 16'h0);
      check("R10 flags", {8'h0, flag_o}, 16'h0);
      check("R1 cnt in reset", cnt_o, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 cnt first", cnt_o, 16'd1);
      @(negedge clk);
      check("R1 cnt second", cnt_o, 16'd2);
   endtask

   // R3 / R4 / R11: every action code on channel 2
   task automatic t_actions;
      logic [15:0] t;
      set_ch(2, 1'b1, 2'b11, 1'b0, 1'b0);
      check("R4 oe set code", {15'h0, pin_oe_o[2]}, 16'd1);
      future(t); wr(4'd2, t); wait_cnt(t + 16'd1);
      check("R3 set", {15'h0, pin_o[2]}, 16'd1);
      check("R2 flag ch2", {15'h0, flag_o[2]}, 16'd1);
      wr(4'd12, 16'h0004);
      @(negedge clk);
      check("R2 clear ch2", {15'h0, flag_o[2]}, 16'd0);
      set_ch(2, 1'b1, 2'b10, 1'b0, 1'b0);
      future(t); wr(4'd2, t); wait_cnt(t + 16'd1);
      check("R3 clear", {15'h0, pin_o[2]}, 16'd0);
      set_ch(2, 1'b1, 2'b01, 1'b0, 1'b0);
      future(t); wr(4'd2, t); wait_cnt(t + 16'd1);
      check("R3 toggle", {15'h0, pin_o[2]}, 16'd1);
      set_ch(2, 1'b1, 2'b00, 1'b0, 1'b0);
      check("R4 oe off code", {15'h0, pin_oe_o[2]}, 16'd0);
      future(t); wr(4'd2, t); wait_cnt(t + 16'd1);
      check("R3 code 00 keeps pin", {15'h0, pin_o[2]}, 16'd1);
      check("R3 code 00 still flags", {15'h0, flag_o[2]}, 16'd1);
   endtask

   // R2: clear with zero, clear with one, clear colliding with a match
   task automatic t_flags;
      logic [15:0] t;
      set_ch(5, 1'b1, 2'b00, 1'b0, 1'b0);
      future(t); wr(4'd5, t); wait_cnt(t + 16'd1);
      check("R2 flag ch5 set", {15'h0, flag_o[5]}, 16'd1);
      wr(4'd12, 16'h0000);
      @(negedge clk);
      check("R2 zero write keeps", {15'h0, flag_o[5]}, 16'd1);
      wr(4'd12, 16'h0020);
      @(negedge clk);
      check("R2 one write clears", {15'h0, flag_o[5]}, 16'd0);
      future(t); wr(4'd5, t); wait_cnt(t);
      wr_en = 1'b1; wr_addr = 4'd12; wr_data = 16'h0020;
      @(negedge clk);
      wr_en = 1'b0;
      check("R2 match beats clear", {15'h0, flag_o[5]}, 16'd1);
   endtask

   // R9: channel not in compare mode
   task automatic t_mode_off;
      logic [15:0] t;
      set_ch(4, 1'b0, 2'b11, 1'b0, 1'b0);
      check("R4 oe mode off", {15'h0, pin_oe_o[4]}, 16'd0);
      future(t); wr(4'd4, t); wait_cnt(t + 16'd1);
      check("R9 no flag", {15'h0, flag_o[4]}, 16'd0);
      check("R9 pin unchanged", {15'h0, pin_o[4]}, 16'd0);
   endtask

   // R5 / R6: master and masked channel on the same count
   task automatic t_simul;
      logic [15:0] t;
      set_ch(1, 1'b1, 2'b00, 1'b0, 1'b1);
      set_ch(6, 1'b0, 2'b00, 1'b1, 1'b1);
      set_ch(3, 1'b1, 2'b10, 1'b1, 1'b1);
      set_ch(7, 1'b1, 2'b11, 1'b0, 1'b0);
      check("R4 oe by mask", {15'h0, pin_oe_o[3]}, 16'd1);
      future(t); wr(4'd3, t); wr(4'd7, t); wait_cnt(t + 16'd1);
      check("R6 data beats own clear", {15'h0, pin_o[3]}, 16'd1);
      check("R8 ch7 own set", {15'h0, pin_o[7]}, 16'd1);
      check("R5 unmasked untouched", {15'h0, pin_o[1]}, 16'd0);
      check("R5 mode-off masked untouched", {15'h0, pin_o[6]}, 16'd0);
      check("R2 both flags", {14'h0, flag_o[7], flag_o[3]}, 16'd3);
   endtask

   // R7: staggered events, both orders
   task automatic t_stagger;
      logic [15:0] t;
      set_ch(3, 1'b1, 2'b11, 1'b1, 1'b0);
      future(t); wr(4'd7, t); wr(4'd3, t + 16'd8);
      wait_cnt(t + 16'd1);
      check("R7 master first", {15'h0, pin_o[3]}, 16'd0);
      wait_cnt(t + 16'd9);
      check("R7 own second", {15'h0, pin_o[3]}, 16'd1);
      set_ch(3, 1'b1, 2'b10, 1'b1, 1'b1);
      future(t); wr(4'd3, t); wr(4'd7, t + 16'd8);
      wait_cnt(t + 16'd1);
      check("R7 own first", {15'h0, pin_o[3]}, 16'd0);
      wait_cnt(t + 16'd9);
      check("R7 master second", {15'h0, pin_o[3]}, 16'd1);
   endtask

   // R8 / R4: channel 7 with its own mask bit set and cleared
   task automatic t_master_self;
      logic [15:0] t;
      set_ch(7, 1'b1, 2'b11, 1'b1, 1'b0);
      future(t); wr(4'd7, t); wait_cnt(t + 16'd1);
      check("R8 mask7 set takes data", {15'h0, pin_o[7]}, 16'd0);
      set_ch(7, 1'b1, 2'b11, 1'b0, 1'b0);
      future(t); wr(4'd7, t); wait_cnt(t + 16'd1);
      check("R8 mask7 clear own action", {15'h0, pin_o[7]}, 16'd1);
      set_ch(7, 1'b1, 2'b00, 1'b0, 1'b0);
      check("R4 ch7 released", {15'h0, pin_oe_o[7]}, 16'd0);
      set_ch(7, 1'b1, 2'b00, 1'b1, 1'b0);
      check("R4 ch7 held by mask", {15'h0, pin_oe_o[7]}, 16'd1);
   endtask

   // R1: counter wrap
   task automatic t_wrap;
      wait_cnt(16'hFFFF);
      @(negedge clk);
      check("R1 wrap", cnt_o, 16'h0000);
   endtask

   initial begin
      t_reset();
      t_actions();
      t_flags();
      t_mode_off();
      t_simul();
      t_stagger();
      t_master_self();
      t_wrap();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule